// File: doc/BRIEF.md
# One-Shot Strap Sampler

This block takes a single snapshot of a word of general-purpose input pins after reset and holds it for the rest of the reset epoch. Boot logic uses such a snapshot to read board-level configuration straps. A strobe starts the capture. On the first clock edge where the strobe is high, the block stores the pin word and sets a valid flag in the same update.

After that first capture the block is locked. Holding the strobe high, pulsing it again or moving the pins does not change the stored word or the flag. Only a reset clears them.

The stored word and the flag are driven straight to output ports for hardware consumers. Software reads them through a small read-only register port, where each read returns its result on the cycle after the strobe. The pin word is assumed to be synchronized already, and the strobe is treated as synchronous to the block clock.

Top module: `strap_sampler`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), `strap_data_o`, `strap_valid_o` and `csr_rdata_o` are all zero.
- R2: The block registers the pin word internally once per cycle. The first rising edge that sees `strap_en` high with `strap_valid_o` low loads `strap_data_o` with the pin word registered on the previous edge and sets `strap_valid_o` to 1 at the same edge. A pin change that arrives less than one cycle before the strobe is therefore not captured.
- R3: If `strap_en` is held high for several cycles, only the first cycle captures. The data stays equal to that first capture.
- R4: Once `strap_valid_o` is 1, further `strap_en` pulses leave `strap_data_o` and `strap_valid_o` unchanged until the next reset.
- R5: Once `strap_valid_o` is 1, changes of `gpio_in` leave `strap_data_o` unchanged.
- R6: A read strobe with byte offset 0x0 returns the strap data in `csr_rdata_o`, zero-extended, one cycle after the strobe.
- R7: A read strobe with byte offset 0x4 returns the valid flag in bit 0 and zeros in bits 31:1, one cycle after the strobe.
- R8: A read of any other offset returns zero. `csr_rdata_o` is zero in any cycle that follows a cycle without a read strobe.
- R9: Reads have no side effects on the strap data or the valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_en | input | 1 | Capture strobe, already synchronous |
| gpio_in | input | GPIO_W (32) | Synchronized pin word |
| csr_addr | input | ADDR_W (4) | Byte offset of the register read |
| csr_rd | input | 1 | Read strobe |
| strap_data_o | output | GPIO_W (32) | Captured pin word |
| strap_valid_o | output | 1 | Capture has taken place |
| csr_rdata_o | output | DATA_W (32) | Read data, valid the cycle after csr_rd |

## Verification
A lock flag that clears or never sets shows up at the ports within one cycle of the next strobe. In that case a second `strap_en` pulse overwrites `strap_data_o`, and the bench flags the new data word at the following sample point. An error in the one-cycle input register makes the capture take the pin word of the wrong cycle. The bench changes the pins on the same cycle as the strobe to expose that case. A wrong read decode appears in `csr_rdata_o` one cycle after the strobe, and the reference model compares that value on every clock.

// File: rtl/strap_pkg.sv
// Shared constants for the strap sampler: register offsets and read selector.
package strap_pkg;
    localparam int unsigned OFS_DATA  = 32'h0;
    localparam int unsigned OFS_VALID = 32'h4;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_DATA  = 2'd1,
        SEL_VALID = 2'd2
    } rd_sel_e;
endpackage

// File: rtl/strap_capture.sv
// Registers the pin word and performs the single capture per reset.
// Assumes gpio_in and strap_en are synchronous to clk.
module strap_capture #(
    parameter int unsigned GPIO_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_en,
    input  logic [GPIO_W-1:0] gpio_in,
    output logic [GPIO_W-1:0] data_q,
    output logic              valid_q
);
    logic [GPIO_W-1:0] pins_q;
    logic              fire;

    // One-cycle input register: the capture source lags the pins by a cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pins_q <= '0;
        else        pins_q <= gpio_in;
    end

    // Trigger: strobe high while not yet captured.
    always_comb fire = strap_en && !valid_q;

    // Capture register and sticky flag, both updated in the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else if (fire) begin
            data_q  <= pins_q;
            valid_q <= 1'b1;
        end
    end

    // R2
    valid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> $past(strap_en));
    // R4
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> valid_q);
    // R5
    data_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> $stable(data_q));
endmodule

// File: rtl/strap_csr_read.sv
// Read-only register port: decodes the byte offset and returns the selected
// value one cycle after the strobe; zero when there is no strobe.
module strap_csr_read
    import strap_pkg::*;
#(
    parameter int unsigned GPIO_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              csr_rd,
    input  logic [GPIO_W-1:0] data_q,
    input  logic              valid_q,
    output logic [DATA_W-1:0] rdata_q
);
    rd_sel_e           sel;
    logic [DATA_W-1:0] rdata_d;

    // Offset decode.
    always_comb begin
        if (csr_addr == ADDR_W'(OFS_DATA))       sel = SEL_DATA;
        else if (csr_addr == ADDR_W'(OFS_VALID)) sel = SEL_VALID;
        else                                     sel = SEL_NONE;
    end

    // Read mux with zero extension.
    always_comb begin
        rdata_d = '0;
        if (csr_rd) begin
            case (sel)
                SEL_DATA:  rdata_d[GPIO_W-1:0] = data_q;
                SEL_VALID: rdata_d[0]          = valid_q;
                default:   rdata_d             = '0;
            endcase
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_rd |=> rdata_q == '0);
    // R7
    valid_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd && csr_addr == ADDR_W'(OFS_VALID)) |=> rdata_q[DATA_W-1:1] == '0);
endmodule

// File: rtl/strap_sampler.sv
// Top of the one-shot strap sampler: capture core plus register read port.
// Assumes GPIO_W <= DATA_W and synchronous inputs.
module strap_sampler #(
    parameter int unsigned GPIO_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_en,
    input  logic [GPIO_W-1:0] gpio_in,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              csr_rd,
    output logic [GPIO_W-1:0] strap_data_o,
    output logic              strap_valid_o,
    output logic [DATA_W-1:0] csr_rdata_o
);
    logic [GPIO_W-1:0] data_q;
    logic              valid_q;

    strap_capture #(.GPIO_W(GPIO_W)) i_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_en (strap_en),
        .gpio_in  (gpio_in),
        .data_q   (data_q),
        .valid_q  (valid_q)
    );

    strap_csr_read #(.GPIO_W(GPIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .csr_addr (csr_addr),
        .csr_rd   (csr_rd),
        .data_q   (data_q),
        .valid_q  (valid_q),
        .rdata_q  (csr_rdata_o)
    );

    assign strap_data_o  = data_q;
    assign strap_valid_o = valid_q;

    // R9
    read_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd && !strap_en) |=> $stable(strap_data_o) && $stable(strap_valid_o));
endmodule

// File: tb/test_strap_sampler.sv
module test_strap_sampler;
    localparam int GW = 32;
    localparam int AW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strap_en = 1'b0;
    logic [GW-1:0] gpio_in = '0;
    logic [AW-1:0] csr_addr = '0;
    logic          csr_rd = 1'b0;
    logic [GW-1:0] strap_data_o;
    logic          strap_valid_o;
    logic [DW-1:0] csr_rdata_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string phase = "R1";

    // Reference model state.
    logic [GW-1:0] m_pins = '0, m_data = '0;
    logic          m_valid = 1'b0;
    logic [DW-1:0] m_rdata = '0;

    strap_sampler i_strap_sampler (
        .clk(clk), .rst_n(rst_n), .strap_en(strap_en), .gpio_in(gpio_in),
        .csr_addr(csr_addr), .csr_rd(csr_rd), .strap_data_o(strap_data_o),
        .strap_valid_o(strap_valid_o), .csr_rdata_o(csr_rdata_o)
    );

    always #5 clk = ~clk;

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Behavioural model, updated at every edge from the inputs before it.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_pins = '0; m_data = '0; m_valid = 1'b0; m_rdata = '0;
        end else begin
            if (!csr_rd)                  m_rdata = '0;
            else if (csr_addr == 4'h0)    m_rdata = DW'(m_data);
            else if (csr_addr == 4'h4)    m_rdata = DW'(m_valid);
            else                          m_rdata = '0;
            if (strap_en && !m_valid) begin
                m_data  = m_pins;
                m_valid = 1'b1;
            end
            m_pins = gpio_in;
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        chk({phase, " data"},  DW'(strap_data_o), DW'(m_data));
        chk({phase, " valid"}, DW'(strap_valid_o), DW'(m_valid));
        chk({phase, " rdata"}, csr_rdata_o, m_rdata);
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic rd(logic [AW-1:0] a);
        csr_addr = a; csr_rd = 1'b1;
        step(1);
        csr_rd = 1'b0;
    endtask

    initial begin
        step(3);
        phase = "R1";
        chk("R1 reset data", DW'(strap_data_o), '0);
        chk("R1 reset valid", DW'(strap_valid_o), '0);
        rst_n = 1'b1;
        rd(4'h0); chk("R1 read data after reset", csr_rdata_o, '0);
        rd(4'h4); chk("R1 read valid after reset", csr_rdata_o, '0);

        // R2: strobe and a new pin word on the same cycle; the older word is captured.
        phase = "R2";
        gpio_in = 32'hA5A5_0F0F; step(2);
        gpio_in = 32'h1234_5678; strap_en = 1'b1;
        step(1);
        chk("R2 captured word", DW'(strap_data_o), 32'hA5A5_0F0F);
        chk("R2 valid set", DW'(strap_valid_o), 1);

        // R3: strobe held while pins move.
        phase = "R3";
        gpio_in = 32'hDEAD_BEEF; step(1);
        gpio_in = 32'h0000_FFFF; step(2);
        strap_en = 1'b0; step(1);
        chk("R3 single capture", DW'(strap_data_o), 32'hA5A5_0F0F);

        // R4: later pulses.
        phase = "R4";
        for (int k = 0; k < 3; k++) begin
            gpio_in = 32'h0F0F_0000 + k; step(1);
            strap_en = 1'b1; step(1);
            strap_en = 1'b0; step(1);
        end
        chk("R4 data frozen", DW'(strap_data_o), 32'hA5A5_0F0F);
        chk("R4 valid held", DW'(strap_valid_o), 1);

        // R5: pin activity.
        phase = "R5";
        for (int k = 0; k < 8; k++) begin
            gpio_in = 32'h1 << (k * 4); step(1);
        end
        chk("R5 data frozen", DW'(strap_data_o), 32'hA5A5_0F0F);

        // R6/R7/R8/R9: reads.
        phase = "R6";
        rd(4'h0); chk("R6 read data", csr_rdata_o, 32'hA5A5_0F0F);
        phase = "R7";
        rd(4'h4); chk("R7 read valid", csr_rdata_o, 32'h1);
        phase = "R8";
        rd(4'h8); chk("R8 read 0x8", csr_rdata_o, '0);
        rd(4'hC); chk("R8 read 0xC", csr_rdata_o, '0);
        csr_addr = 4'h0; step(1);
        chk("R8 no strobe", csr_rdata_o, '0);
        phase = "R9";
        for (int k = 0; k < 4; k++) rd(AW'(k * 4));
        chk("R9 data after reads", DW'(strap_data_o), 32'hA5A5_0F0F);

        // R1 again, then a fresh capture in the new epoch.
        phase = "R1";
        rst_n = 1'b0; step(2);
        chk("R1 second reset data", DW'(strap_data_o), '0);
        chk("R1 second reset valid", DW'(strap_valid_o), '0);
        rst_n = 1'b1;
        phase = "R2";
        gpio_in = 32'h5A5A_C3C3; step(2);
        strap_en = 1'b1; step(1);
        strap_en = 1'b0;
        chk("R2 second epoch capture", DW'(strap_data_o), 32'h5A5A_C3C3);
        step(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule